// File: doc/BRIEF.md
# QDR SRAM Read Return Aligner

This block sits in a host memory controller between a read request source and the sampled read-data lane of a quad- or double-data-rate synchronous SRAM. It runs on a clock at twice the memory clock, so one tick is half a memory cycle. It accepts read requests, sends a burst-aligned read command to the device, and predicts the return tick from a read latency fixed at build time. It then gathers the returned words of each burst into one wide response word.

The read latency is set in half-cycle ticks. A value of 3 gives 1.5 memory cycles and suits the older device class. Values of 4 and 5 give 2.0 and 2.5 cycles and suit the faster class. The burst length is 2 or 4 words, and each word takes one tick on the data lane.

When the valid-strobe mode is on, the device's output-valid input leads the first data word by one tick and starts the capture. The block compares that strobe with its own prediction and raises a sticky error flag when the two disagree. Deassertion of `rst_n` is expected to be synchronous to `clk`.

Top module: `qdr_rd_aligner`

## Requirements
- R1: While reset is held and on the first tick after it, `req_ready` is 1, and `rsp_valid`, `err_flag` and `mem_rd` are 0.
- R2: The first data word of a read is sampled LAT2 ticks after the tick on which the request is accepted. The device strobe for that read is expected on tick LAT2-1. LAT2 is 3, 4 or 5 and is a build parameter.
- R3: On the accept tick, `mem_rd` is 1 and `mem_addr` equals `req_addr` with its low log2(BURST) bits forced to zero. The requested low address bits have no effect on the returned data or its order.
- R4: Returned word k of a burst (k = 0 for the first word on the lane) is placed at bits [k*DW +: DW] of `rsp_data`.
- R5: `rsp_valid` is high for exactly one tick: the tick after the last word of the burst was sampled. That is the accept tick plus LAT2 + BURST.
- R6: After a request is accepted, `req_ready` stays low for BURST-1 ticks. A request held during that time is stalled and is accepted on the next tick with `req_ready` high, so accepted reads are exactly BURST ticks apart.
- R7: In valid-strobe mode, capture starts on the tick after `rd_vld` is sampled high, whether or not a read was predicted. A strobe with no read outstanding still yields a response built from the following BURST words.
- R8: In valid-strobe mode, `err_flag` is set one tick after any tick on which `rd_vld` differs from the prediction (missing where a read is predicted, or present where none is). It then stays set.
- R9: A tick with `err_clr` high clears `err_flag` on the next tick, unless a new mismatch occurs on that same tick. In that case the flag stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock, twice the memory clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request present |
| req_addr | input | AW | Read request word address |
| req_ready | output | 1 | Request can be accepted this tick |
| mem_rd | output | 1 | Read command to the device on this tick |
| mem_addr | output | AW | Burst-aligned command address |
| rd_vld | input | 1 | Sampled device output-valid strobe |
| rd_data | input | DW | Sampled read data lane |
| err_clr | input | 1 | Clears the sticky error flag |
| rsp_valid | output | 1 | One-tick pulse: `rsp_data` holds a full burst |
| rsp_data | output | DW*BURST | Assembled burst, word 0 in the low bits |
| err_flag | output | 1 | Sticky strobe/prediction mismatch flag |

## Verification
A latency pipeline that is off by one tick first shows up on `err_flag`. The flag goes high on the tick after the strobe that was not predicted, several ticks before any response would arrive. A capture index or start state that is wrong shows up on the next `rsp_valid`. The pulse either lands on a tick other than accept + LAT2 + BURST, lasts two ticks, or carries words in the wrong lanes. A spacing counter that is wrong is seen on `req_ready` within BURST ticks of an accept, and in the gaps between held back-to-back requests.

// File: rtl/qra_pkg.sv
package qra_pkg;

  typedef enum logic {
    CAP_IDLE = 1'b0,
    CAP_RUN  = 1'b1
  } cap_state_e;

  // number of address bits covered by one burst
  function automatic int burst_bits(input int burst);
    return (burst == 4) ? 2 : 1;
  endfunction

endpackage

// File: rtl/qra_issue.sv
module qra_issue #(
  parameter int BURST = 4,
  parameter int AW    = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  output logic          req_ready,
  output logic          issue,
  output logic [AW-1:0] mem_addr
);
  import qra_pkg::*;

  localparam int OB = burst_bits(BURST);
  localparam int GW = OB;

  logic [GW-1:0] gap_q, gap_d;
  logic          gap_en;

  assign req_ready = (gap_q == '0);
  assign issue     = req_valid & req_ready;
  assign mem_addr  = {req_addr[AW-1:OB], {OB{1'b0}}};

  always_comb begin
    gap_en = issue | (gap_q != '0);
    if (issue) gap_d = GW'(BURST - 1);
    else       gap_d = gap_q - GW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      gap_q <= '0;
    else if (gap_en) gap_q <= gap_d;
  end
endmodule

// File: rtl/qra_track.sv
module qra_track #(
  parameter int LAT2     = 4,
  parameter bit VLD_MODE = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic issue,
  input  logic dev_vld,
  input  logic err_clr,
  output logic pred_first,
  output logic err_flag
);
  logic [LAT2-1:0] pipe_q, pipe_d;
  logic            mismatch;
  logic            err_q, err_d, err_en;

  assign pipe_d     = {pipe_q[LAT2-2:0], issue};
  assign pred_first = pipe_q[LAT2-1];
  assign err_flag   = err_q;

  generate
    if (VLD_MODE) begin : g_chk
      assign mismatch = dev_vld ^ pipe_q[LAT2-2];
    end else begin : g_nochk
      assign mismatch = 1'b0 & dev_vld;
    end
  endgenerate

  always_comb begin
    err_en = mismatch | err_clr;
    err_d  = mismatch | (err_q & ~err_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= pipe_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      err_q <= 1'b0;
    else if (err_en) err_q <= err_d;
  end
endmodule

// File: rtl/qra_pack.sv
module qra_pack #(
  parameter int DW       = 8,
  parameter int BURST    = 4,
  parameter bit VLD_MODE = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                dev_vld,
  input  logic                pred_first,
  input  logic [DW-1:0]       dev_data,
  output logic                rsp_valid,
  output logic [DW*BURST-1:0] rsp_data
);
  import qra_pkg::*;

  localparam int IW = burst_bits(BURST);
  localparam logic [IW-1:0] LAST = IW'(BURST - 1);

  cap_state_e    st_q, st_d;
  logic [IW-1:0] idx_q, idx_d;
  logic          vld_q, start, last_word;
  logic          done_q;

  assign start     = VLD_MODE ? vld_q : pred_first;
  assign last_word = (st_q == CAP_RUN) && (idx_q == LAST);

  always_comb begin
    st_d  = st_q;
    idx_d = idx_q;
    if (st_q == CAP_IDLE) begin
      if (start) begin
        st_d  = CAP_RUN;
        idx_d = IW'(1);
      end
    end else begin
      idx_d = idx_q + IW'(1);
      if (last_word) st_d = CAP_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= CAP_IDLE;
      idx_q  <= '0;
      vld_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      vld_q  <= dev_vld;
      done_q <= last_word;
    end
  end

  genvar gi;
  generate
    for (gi = 0; gi < BURST; gi++) begin : g_word
      logic [DW-1:0] w_q;
      logic          w_en;
      if (gi == 0) begin : g_first
        assign w_en = (st_q == CAP_IDLE) && start;
      end else begin : g_rest
        assign w_en = (st_q == CAP_RUN) && (idx_q == IW'(gi));
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    w_q <= '0;
        else if (w_en) w_q <= dev_data;
      end
      assign rsp_data[gi*DW +: DW] = w_q;
    end
  endgenerate

  assign rsp_valid = done_q;
endmodule

// File: rtl/qdr_rd_aligner.sv
module qdr_rd_aligner #(
  parameter int LAT2     = 4,
  parameter int BURST    = 4,
  parameter int DW       = 8,
  parameter int AW       = 10,
  parameter bit VLD_MODE = 1'b1,
  parameter int MEM_MHZ  = 500
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [AW-1:0]       req_addr,
  output logic                req_ready,
  output logic                mem_rd,
  output logic [AW-1:0]       mem_addr,
  input  logic                rd_vld,
  input  logic [DW-1:0]       rd_data,
  input  logic                err_clr,
  output logic                rsp_valid,
  output logic [DW*BURST-1:0] rsp_data,
  output logic                err_flag
);
  logic issue;
  logic pred_first;

  qra_issue #(.BURST(BURST), .AW(AW)) u_issue (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_ready(req_ready), .issue(issue), .mem_addr(mem_addr)
  );

  qra_track #(.LAT2(LAT2), .VLD_MODE(VLD_MODE)) u_track (
    .clk(clk), .rst_n(rst_n), .issue(issue), .dev_vld(rd_vld),
    .err_clr(err_clr), .pred_first(pred_first), .err_flag(err_flag)
  );

  qra_pack #(.DW(DW), .BURST(BURST), .VLD_MODE(VLD_MODE)) u_pack (
    .clk(clk), .rst_n(rst_n), .dev_vld(rd_vld), .pred_first(pred_first),
    .dev_data(rd_data), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  assign mem_rd = issue;
endmodule

// File: rtl/qdr_rd_aligner_chk.sv
module qdr_rd_aligner_chk #(
  parameter int LAT2     = 4,
  parameter int BURST    = 4,
  parameter int AW       = 10,
  parameter bit VLD_MODE = 1'b1,
  parameter int MEM_MHZ  = 500
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          mem_rd,
  input logic [AW-1:0] mem_addr,
  input logic          rd_vld,
  input logic          err_clr,
  input logic          err_flag,
  input logic          rsp_valid
);
  localparam int OB = qra_pkg::burst_bits(BURST);

  initial begin
    if (LAT2 < 3 || LAT2 > 5)
      $error("read latency must be 3, 4 or 5 half-cycle ticks");
    if (BURST != 2 && BURST != 4)
      $error("burst length must be 2 or 4");
    if (BURST == 2 && LAT2 >= 4 && MEM_MHZ > 333)
      $error("burst-2 setup of the faster class is limited to 333 MHz");
  end

  // R6: an accept blocks the following tick
  assert_spacing_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R3: command address is burst aligned
  assert_cmd_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> (mem_addr[OB-1:0] == '0));

  // R5: response pulse lasts one tick
  assert_rsp_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R8: error flag holds without a clear
  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !err_clr) |=> err_flag);

  generate
    if (VLD_MODE) begin : g_vld
      // R7: every response follows a strobe BURST+1 ticks earlier
      assert_rsp_after_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(rd_vld, BURST + 1));
    end
  endgenerate
endmodule

bind qdr_rd_aligner qdr_rd_aligner_chk #(
  .LAT2(LAT2), .BURST(BURST), .AW(AW), .VLD_MODE(VLD_MODE), .MEM_MHZ(MEM_MHZ)
) i_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .mem_rd(mem_rd), .mem_addr(mem_addr), .rd_vld(rd_vld), .err_clr(err_clr),
  .err_flag(err_flag), .rsp_valid(rsp_valid)
);

// File: tb/test_qdr_rd_aligner.sv
`timescale 1ns/1ps
module test_qdr_rd_aligner;
  localparam int LAT2  = 4;
  localparam int BURST = 4;
  localparam int DW    = 8;
  localparam int AW    = 10;
  localparam int BW    = DW * BURST;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic          req_ready, mem_rd;
  logic [AW-1:0] mem_addr;
  logic          rd_vld = 1'b0;
  logic [DW-1:0] rd_data = '0;
  logic          err_clr = 1'b0;
  logic          rsp_valid, err_flag;
  logic [BW-1:0] rsp_data;

  int  cyc = 0;
  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 1'b0;
  bit  vld_at [int];
  logic [DW-1:0] dat_at [int];
  logic [BW-1:0] exp_q [$];
  int            expc_q [$];

  qdr_rd_aligner #(.LAT2(LAT2), .BURST(BURST), .DW(DW), .AW(AW)) i_qdr_rd_aligner (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_ready(req_ready), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .rd_vld(rd_vld), .rd_data(rd_data), .err_clr(err_clr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .err_flag(err_flag)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(input logic [AW-1:0] base, input int k);
    return (base[DW-1:0] + DW'(k * 8'h11)) ^ 8'h5A;
  endfunction

  // device model: drives strobe and data scheduled per tick
  always @(negedge clk) begin
    rd_vld  = vld_at.exists(cyc);
    rd_data = dat_at.exists(cyc) ? dat_at[cyc] : '0;
  end

  // monitor: compares responses with the scoreboard
  bit prev_rsp = 1'b0;
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      chk(!prev_rsp, "R5", "pulse width", 64'(prev_rsp), 64'(0));
      if (exp_q.size() == 0) begin
        chk(1'b0, "R7", "unexpected response", 64'(rsp_data), 64'(0));
      end else begin
        logic [BW-1:0] e;
        int ec;
        e  = exp_q.pop_front();
        ec = expc_q.pop_front();
        chk(rsp_data == e, "R4", "packed burst", 64'(rsp_data), 64'(e));
        chk(cyc == ec, "R5", "response tick", 64'(cyc), 64'(ec));
      end
    end
    prev_rsp = rst_n && rsp_valid;
  end

  // driver: issues one read, schedules the device return, pushes expectation
  task automatic do_read(input logic [AW-1:0] a, input bit drop, output int acc);
    logic [AW-1:0] base;
    logic [BW-1:0] e;
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    #1;
    while (!req_ready) begin
      @(negedge clk);
      #1;
    end
    acc  = cyc;
    base = {a[AW-1:2], 2'b00};
    chk(mem_rd == 1'b1, "R3", "command strobe", 64'(mem_rd), 64'(1));
    chk(mem_addr == base, "R3", "aligned address", 64'(mem_addr), 64'(base));
    if (!drop) vld_at[acc + LAT2 - 1] = 1'b1;
    for (int k = 0; k < BURST; k++) begin
      dat_at[acc + LAT2 + k] = pat(base, k);
      e[k*DW +: DW] = pat(base, k);
    end
    if (!drop) begin
      exp_q.push_back(e);
      expc_q.push_back(acc + LAT2 + BURST);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
      err_clr   = 1'b0;
    end
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int a0, a1, a2, a3, x;
    logic [BW-1:0] e;
    repeat (3) @(negedge clk);
    #1;
    chk(req_ready == 1'b1, "R1", "ready in reset", 64'(req_ready), 64'(1));
    chk(rsp_valid == 1'b0, "R1", "rsp_valid in reset", 64'(rsp_valid), 64'(0));
    chk(err_flag == 1'b0, "R1", "err in reset", 64'(err_flag), 64'(0));
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(mem_rd == 1'b0, "R1", "mem_rd after reset", 64'(mem_rd), 64'(0));
    chk(req_ready == 1'b1, "R1", "ready after reset", 64'(req_ready), 64'(1));
    idle(2);

    // single read, then spacing window (R2, R6)
    do_read(10'h040, 1'b0, a0);
    for (int k = 1; k < BURST; k++) begin
      @(negedge clk);
      req_valid = 1'b0;
      #1;
      chk(req_ready == 1'b0, "R6", "ready low in gap", 64'(req_ready), 64'(0));
    end
    @(negedge clk);
    #1;
    chk(req_ready == 1'b1, "R6", "ready back", 64'(req_ready), 64'(1));
    idle(12);

    // held back-to-back requests with unaligned addresses (R3, R6, R2)
    do_read(10'h123, 1'b0, a1);
    do_read(10'h2B6, 1'b0, a2);
    do_read(10'h0FD, 1'b0, a3);
    chk(a2 - a1 == BURST, "R6", "accept spacing 1", 64'(a2 - a1), 64'(BURST));
    chk(a3 - a2 == BURST, "R6", "accept spacing 2", 64'(a3 - a2), 64'(BURST));
    idle(16);
    chk(err_flag == 1'b0, "R8", "no false error", 64'(err_flag), 64'(0));

    // missing strobe (R8, R9)
    do_read(10'h155, 1'b1, a0);
    idle(LAT2 + 2);
    chk(err_flag == 1'b1, "R8", "missing strobe", 64'(err_flag), 64'(1));
    idle(6);
    chk(err_flag == 1'b1, "R8", "flag sticky", 64'(err_flag), 64'(1));
    @(negedge clk);
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
    #1;
    chk(err_flag == 1'b0, "R9", "clear", 64'(err_flag), 64'(0));
    idle(4);

    // stray strobe with no read outstanding (R7, R8)
    @(negedge clk);
    x = cyc;
    vld_at[x + 1] = 1'b1;
    for (int k = 0; k < BURST; k++) begin
      dat_at[x + 2 + k] = 8'hC0 + DW'(k);
      e[k*DW +: DW] = 8'hC0 + DW'(k);
    end
    exp_q.push_back(e);
    expc_q.push_back(x + 2 + BURST);
    idle(3);
    chk(err_flag == 1'b1, "R8", "stray strobe", 64'(err_flag), 64'(1));
    idle(10);
    @(negedge clk);
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
    #1;
    chk(err_flag == 1'b0, "R9", "clear after stray", 64'(err_flag), 64'(0));

    // one more clean read after recovery (R2, R4)
    do_read(10'h3FF, 1'b0, a0);
    idle(20);
    chk(exp_q.size() == 0, "R5", "all responses seen", 64'(exp_q.size()), 64'(0));
    chk(err_flag == 1'b0, "R8", "clean after recovery", 64'(err_flag), 64'(0));
    finish_run();
  end
endmodule